// File: doc/BRIEF.md
# Memory ECC Error Logger and Scrubber

This block sits next to a 72-bit protected memory path (64 data bits and 8 check bits). The external error-correcting decoder classifies each checked read. The block receives one result per read: no error, a corrected single-bit error, or an uncorrectable multi-bit error. Each result comes with the memory row identifier, the word address and the corrected 72-bit word. The block does not assume any ordering of the bits inside that word.

For every corrected error, the block raises a scrub write request that carries the corrected word and its address. The memory controller writes the word back, so software never has to rewrite failing locations. The block keeps two independent sticky error classes: correctable and uncorrectable. Each class has its own flag and its own first-error row field. A two-bit command register selects which classes pulse the active-low system-error output. While the array is being initialised, all reports are discarded, because the check bits are not yet valid.

The read-result input is a valid-only stream. It is always accepted and has no back-pressure. The scrub request is a valid/ready stream. Once raised, the request and its address and word hold steady until ready is seen high on a clock edge. A correctable error that arrives while a request is outstanding, including the acknowledge cycle, is logged but produces no second request. The command, clear and status pins are plain level signals.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, both flags and both row fields are 0, the command register is 0, scrub_valid_o is 0 and serr_n_o is 1.
- R2: A report with rd_valid_i=1 and rd_kind_i=2'b01 (correctable) sets sbe_flag_o on the next clock. If that flag was clear, it also loads rd_row_i into sbe_row_o. The code 2'b00 means no error, and the code 2'b11 is reserved and has no effect on any output.
- R3: A report with rd_kind_i=2'b10 (uncorrectable) sets mbe_flag_o on the next clock. If that flag was clear, it also loads rd_row_i into mbe_row_o.
- R4: While a class flag is set and not being cleared, later errors of that class do not change its row field. The two classes never affect each other's flag or row.
- R5: A cycle with sts_clr_en_i=1 clears sbe_flag_o where sts_clr_mask_i bit 0 is 1, and clears mbe_flag_o where bit 1 is 1, on the next clock. Flags whose mask bit is 0 are unchanged.
- R6: An error of a class arriving in the same cycle as a clear of that class wins. The flag stays 1 and the row field takes the new row.
- R7: A correctable error while no scrub request is outstanding raises scrub_valid_o on the next clock. It carries scrub_addr_o = rd_addr_i and scrub_word_o = {rd_check_i, rd_data_i}. The request, address and word stay stable until a clock with scrub_ready_i=1, after which scrub_valid_o is 0.
- R8: Correctable errors arriving while scrub_valid_o is 1 are logged but start no new request and change no scrub output. Uncorrectable errors never start a scrub.
- R9: serr_n_o is 0 for exactly the clock following each qualifying error and 1 otherwise. An error qualifies if it is correctable with command bit 0 set, or uncorrectable with command bit 1 set.
- R10: Flags and rows are captured whatever the command register holds.
- R11: While init_mode_i is 1, reports change no flag or row, raise no scrub request and leave serr_n_o at 1.
- R12: A cycle with cmd_wr_en_i=1 loads cmd_wr_data_i into cmd_o on the next clock. Error qualification uses the value cmd_o holds in the cycle of the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_mode_i | input | 1 | Array initialisation in progress; reports ignored |
| rd_valid_i | input | 1 | Checked-read result valid |
| rd_kind_i | input | 2 | 00 none, 01 correctable, 10 uncorrectable, 11 reserved |
| rd_row_i | input | ROW_W | Row identifier of the read |
| rd_addr_i | input | ADDR_W | Word address of the read |
| rd_data_i | input | DATA_W | Corrected data bits |
| rd_check_i | input | CHK_W | Corrected check bits |
| scrub_valid_o | output | 1 | Scrub write request pending |
| scrub_ready_i | input | 1 | Memory controller accepts the scrub write |
| scrub_addr_o | output | ADDR_W | Address to rewrite |
| scrub_word_o | output | DATA_W+CHK_W | Corrected word {check, data} |
| cmd_wr_en_i | input | 1 | Command register write strobe |
| cmd_wr_data_i | input | 2 | Bit 0: signal correctable; bit 1: signal uncorrectable |
| cmd_o | output | 2 | Current command register |
| sts_clr_en_i | input | 1 | Flag clear strobe |
| sts_clr_mask_i | input | 2 | Write-1-to-clear mask: bit 0 correctable, bit 1 uncorrectable |
| sbe_flag_o | output | 1 | Sticky correctable error flag |
| sbe_row_o | output | ROW_W | First correctable error row |
| mbe_flag_o | output | 1 | Sticky uncorrectable error flag |
| mbe_row_o | output | ROW_W | First uncorrectable error row |
| serr_n_o | output | 1 | Active-low system-error pulse |

## Verification
Every result is registered once. Flags, rows, the command register, the scrub request and the system-error pulse all change at the clock edge that samples the stimulus. They are therefore due one edge after the inputs are driven. The bench drives inputs on falling edges and reads outputs on the next falling edge, half a period after the capturing edge. A behavioural model, updated on the same rising edges, is compared against every output at every falling edge. Directed checks then confirm the corner cases: simultaneous clear and error, a report during a pending scrub, the acknowledge cycle, and initialisation mode.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  typedef enum logic [1:0] {
    ECC_NONE = 2'b00,
    ECC_SBE  = 2'b01,
    ECC_MBE  = 2'b10,
    ECC_RSVD = 2'b11
  } ecc_kind_e;

  localparam int unsigned N_CLASS = 2;
  localparam int unsigned CLS_SBE = 0;
  localparam int unsigned CLS_MBE = 1;
endpackage

// File: rtl/ecc_class_status.sv
module ecc_class_status #(
  parameter int unsigned ROW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             flag_o,
  output logic [ROW_W-1:0] row_o
);
  logic capture;
  assign capture = set_i && (!flag_o || clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      row_o  <= '0;
    end else begin
      if (capture) row_o <= row_i;
      if (set_i)       flag_o <= 1'b1;
      else if (clr_i)  flag_o <= 1'b0;
    end
  end

  p_set_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_hold_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> $stable(row_o));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/ecc_scrub_req.sv
module ecc_scrub_req #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      word_o  <= '0;
    end else if (valid_o) begin
      if (ready_i) valid_o <= 1'b0;
    end else if (req_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      word_o  <= word_i;
    end
  end

  p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(word_o)));
  p_no_queue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i) |=> !valid_o);
endmodule

// File: rtl/ecc_serr_gen.sv
module ecc_serr_gen
  import ecc_log_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CLASS-1:0] ev_i,
  input  logic [N_CLASS-1:0] cmd_i,
  output logic               serr_n_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serr_n_o <= 1'b1;
    else        serr_n_o <= ~|(ev_i & cmd_i);
  end
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CHK_W  = 8,
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    init_mode_i,
  input  logic                    rd_valid_i,
  input  logic [1:0]              rd_kind_i,
  input  logic [ROW_W-1:0]        rd_row_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  input  logic [DATA_W-1:0]       rd_data_i,
  input  logic [CHK_W-1:0]        rd_check_i,
  output logic                    scrub_valid_o,
  input  logic                    scrub_ready_i,
  output logic [ADDR_W-1:0]       scrub_addr_o,
  output logic [DATA_W+CHK_W-1:0] scrub_word_o,
  input  logic                    cmd_wr_en_i,
  input  logic [1:0]              cmd_wr_data_i,
  output logic [1:0]              cmd_o,
  input  logic                    sts_clr_en_i,
  input  logic [1:0]              sts_clr_mask_i,
  output logic                    sbe_flag_o,
  output logic [ROW_W-1:0]        sbe_row_o,
  output logic                    mbe_flag_o,
  output logic [ROW_W-1:0]        mbe_row_o,
  output logic                    serr_n_o
);
  localparam int unsigned WORD_W = DATA_W + CHK_W;

  logic                          rpt_ok;
  logic [N_CLASS-1:0]            ev;
  logic [N_CLASS-1:0]            clr;
  logic [N_CLASS-1:0]            flag;
  logic [N_CLASS-1:0][ROW_W-1:0] row;

  assign rpt_ok       = rd_valid_i && !init_mode_i;
  assign ev[CLS_SBE]  = rpt_ok && (rd_kind_i == ECC_SBE);
  assign ev[CLS_MBE]  = rpt_ok && (rd_kind_i == ECC_MBE);
  assign clr          = sts_clr_en_i ? sts_clr_mask_i : '0;

  for (genvar c = 0; c < N_CLASS; c++) begin : g_class
    ecc_class_status #(.ROW_W(ROW_W)) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (ev[c]),
      .clr_i  (clr[c]),
      .row_i  (rd_row_i),
      .flag_o (flag[c]),
      .row_o  (row[c])
    );
  end

  assign sbe_flag_o = flag[CLS_SBE];
  assign mbe_flag_o = flag[CLS_MBE];
  assign sbe_row_o  = row[CLS_SBE];
  assign mbe_row_o  = row[CLS_MBE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cmd_o <= '0;
    else if (cmd_wr_en_i) cmd_o <= cmd_wr_data_i;
  end

  ecc_scrub_req #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_scrub (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (ev[CLS_SBE]),
    .addr_i  (rd_addr_i),
    .word_i  ({rd_check_i, rd_data_i}),
    .valid_o (scrub_valid_o),
    .ready_i (scrub_ready_i),
    .addr_o  (scrub_addr_o),
    .word_o  (scrub_word_o)
  );

  ecc_serr_gen u_serr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (ev),
    .cmd_i    (cmd_o),
    .serr_n_o (serr_n_o)
  );

  p_mbe_signal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_i && !init_mode_i && rd_kind_i == 2'b10 && cmd_o[1]) |=> !serr_n_o);
  p_init_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    init_mode_i |=> serr_n_o);
  p_init_noflag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (init_mode_i && !sts_clr_en_i) |=> ($stable(sbe_flag_o) && $stable(mbe_flag_o)));
  p_cmd_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_en_i |=> (cmd_o == $past(cmd_wr_data_i)));
endmodule

// File: tb/ecc_err_logger_tb.sv
module ecc_err_logger_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 3;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_mode = 1'b0, rd_valid = 1'b0;
  logic [1:0] rd_kind = 2'b00;
  logic [ROW_W-1:0] rd_row = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [63:0] rd_data = '0;
  logic [7:0] rd_check = '0;
  logic scrub_ready = 1'b0;
  logic cmd_wr_en = 1'b0, sts_clr_en = 1'b0;
  logic [1:0] cmd_wr_data = '0, sts_clr_mask = '0;
  logic scrub_valid, sbe_flag, mbe_flag, serr_n;
  logic [ADDR_W-1:0] scrub_addr;
  logic [71:0] scrub_word;
  logic [1:0] cmd;
  logic [ROW_W-1:0] sbe_row, mbe_row;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_logger dut_i (
    .clk(clk), .rst_n(rst_n), .init_mode_i(init_mode), .rd_valid_i(rd_valid),
    .rd_kind_i(rd_kind), .rd_row_i(rd_row), .rd_addr_i(rd_addr), .rd_data_i(rd_data),
    .rd_check_i(rd_check), .scrub_valid_o(scrub_valid), .scrub_ready_i(scrub_ready),
    .scrub_addr_o(scrub_addr), .scrub_word_o(scrub_word), .cmd_wr_en_i(cmd_wr_en),
    .cmd_wr_data_i(cmd_wr_data), .cmd_o(cmd), .sts_clr_en_i(sts_clr_en),
    .sts_clr_mask_i(sts_clr_mask), .sbe_flag_o(sbe_flag), .sbe_row_o(sbe_row),
    .mbe_flag_o(mbe_flag), .mbe_row_o(mbe_row), .serr_n_o(serr_n)
  );

  // Behavioural reference model
  bit m_sf, m_mf, m_sv, m_serr_n;
  int m_srow, m_mrow, m_cmd;
  longint unsigned m_saddr;
  logic [71:0] m_sword;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sf = 0; m_mf = 0; m_sv = 0; m_serr_n = 1;
      m_srow = 0; m_mrow = 0; m_cmd = 0; m_saddr = 0; m_sword = '0;
    end else begin
      bit es, em, cs, cm;
      es = rd_valid && !init_mode && rd_kind == 2'b01;
      em = rd_valid && !init_mode && rd_kind == 2'b10;
      cs = sts_clr_en && sts_clr_mask[0];
      cm = sts_clr_en && sts_clr_mask[1];
      if (es && (!m_sf || cs)) m_srow = int'(rd_row);
      if (em && (!m_mf || cm)) m_mrow = int'(rd_row);
      m_sf = es ? 1 : (cs ? 0 : m_sf);
      m_mf = em ? 1 : (cm ? 0 : m_mf);
      m_serr_n = !((es && m_cmd[0]) || (em && m_cmd[1]));
      if (m_sv) begin
        if (scrub_ready) m_sv = 0;
      end else if (es) begin
        m_sv = 1; m_saddr = rd_addr; m_sword = {rd_check, rd_data};
      end
      if (cmd_wr_en) m_cmd = int'(cmd_wr_data);
    end
  end

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_word(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 sbe flag (model)", sbe_flag, m_sf);
      chk("R3 mbe flag (model)", mbe_flag, m_mf);
      chk("R4 sbe row (model)", sbe_row, m_srow);
      chk("R4 mbe row (model)", mbe_row, m_mrow);
      chk("R7 scrub valid (model)", scrub_valid, m_sv);
      if (m_sv) begin
        chk("R7 scrub addr (model)", scrub_addr, m_saddr);
        chk_word("R7 scrub word (model)", scrub_word, m_sword);
      end
      chk("R9 serr (model)", serr_n, m_serr_n);
      chk("R12 cmd (model)", cmd, m_cmd);
    end
  end

  task automatic idle();
    rd_valid = 0; rd_kind = 2'b00; cmd_wr_en = 0; sts_clr_en = 0; sts_clr_mask = 2'b00;
  endtask

  task automatic set_rd(input logic [1:0] k, input int r, input logic [31:0] a);
    rd_valid = 1; rd_kind = k; rd_row = r[ROW_W-1:0]; rd_addr = a;
    rd_data = {a, ~a}; rd_check = a[7:0] ^ 8'h5A;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sbe flag", sbe_flag, 0); chk("R1 mbe flag", mbe_flag, 0);
    chk("R1 rows", {sbe_row, mbe_row}, 0); chk("R1 scrub", scrub_valid, 0);
    chk("R1 serr", serr_n, 1); chk("R1 cmd", cmd, 0);
    rst_n = 1;
    @(negedge clk);

    // R12: command write
    cmd_wr_en = 1; cmd_wr_data = 2'b11; step();
    chk("R12 cmd loaded", cmd, 2'b11);

    // R2/R7/R9: correctable error, no ack yet
    set_rd(2'b01, 5, 32'h0000_1230); step();
    chk("R2 sbe flag", sbe_flag, 1); chk("R2 sbe row", sbe_row, 5);
    chk("R7 scrub valid", scrub_valid, 1); chk("R7 scrub addr", scrub_addr, 32'h1230);
    chk_word("R7 scrub word", scrub_word, {8'h30 ^ 8'h5A, 32'h1230, ~32'h1230});
    chk("R9 serr low", serr_n, 0);

    // R4/R8: second correctable while scrub pending
    set_rd(2'b01, 2, 32'h0000_4440); step();
    chk("R4 sbe row held", sbe_row, 5); chk("R8 scrub addr kept", scrub_addr, 32'h1230);
    chk("R9 serr low again", serr_n, 0);
    @(negedge clk);
    chk("R9 serr one cycle", serr_n, 1); chk("R7 still pending", scrub_valid, 1);

    // R8: error arriving in the acknowledge cycle is not queued
    scrub_ready = 1; set_rd(2'b01, 1, 32'h0000_7770); step();
    chk("R8 ack cycle no new req", scrub_valid, 0);

    // R3/R8: uncorrectable error
    set_rd(2'b10, 6, 32'h0000_0100); step();
    chk("R3 mbe flag", mbe_flag, 1); chk("R3 mbe row", mbe_row, 6);
    chk("R8 no scrub for mbe", scrub_valid, 0); chk("R9 mbe serr", serr_n, 0);
    set_rd(2'b10, 1, 32'h0000_0200); step();
    chk("R4 mbe row held", mbe_row, 6); chk("R4 sbe row untouched", sbe_row, 5);

    // R5: selective clear
    sts_clr_en = 1; sts_clr_mask = 2'b01; step();
    chk("R5 sbe cleared", sbe_flag, 0); chk("R5 mbe kept", mbe_flag, 1);

    // R6: error and clear in the same cycle
    set_rd(2'b01, 4, 32'h0000_0A00); step();
    chk("R6 pre sbe row", sbe_row, 4);
    set_rd(2'b01, 7, 32'h0000_0B00); sts_clr_en = 1; sts_clr_mask = 2'b01; step();
    chk("R6 flag stays", sbe_flag, 1); chk("R6 row new", sbe_row, 7);

    // R10: command off, flags still latched
    sts_clr_en = 1; sts_clr_mask = 2'b11; cmd_wr_en = 1; cmd_wr_data = 2'b00; step();
    set_rd(2'b10, 2, 32'h0000_0C00); step();
    chk("R10 mbe flag", mbe_flag, 1); chk("R10 mbe row", mbe_row, 2);
    chk("R10 serr quiet", serr_n, 1);

    // R9: command selects class
    cmd_wr_en = 1; cmd_wr_data = 2'b01; step();
    set_rd(2'b10, 3, 32'h0000_0D00); step();
    chk("R9 mbe masked", serr_n, 1);
    set_rd(2'b01, 3, 32'h0000_0E00); step();
    chk("R9 sbe signalled", serr_n, 0);
    @(negedge clk);

    // R2: reserved code ignored
    sts_clr_en = 1; sts_clr_mask = 2'b11; step();
    set_rd(2'b11, 6, 32'h0000_0F00); step();
    chk("R2 rsvd flags", {sbe_flag, mbe_flag}, 0); chk("R2 rsvd serr", serr_n, 1);
    chk("R2 rsvd scrub", scrub_valid, 0);

    // R11: initialisation mode
    init_mode = 1;
    set_rd(2'b01, 1, 32'h0000_1000); step();
    chk("R11 no sbe", sbe_flag, 0); chk("R11 no scrub", scrub_valid, 0);
    chk("R11 serr high", serr_n, 1);
    set_rd(2'b10, 1, 32'h0000_1100); step();
    chk("R11 no mbe", mbe_flag, 0); chk("R11 mbe row", mbe_row, 2);
    init_mode = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule